// File: doc/BRIEF.md
# Configuration Word Access Engine

This block lets software reach a small store of 16-bit configuration words through two 32-bit registers on a simple valid/write bus. The command register holds a launch bit, a direction flag, a completion flag and a word address. The transfer register holds a field for outgoing write data and a separate field where read results land. Software fills in the transfer register if needed, then writes the command register with the launch bit set. One clock later the engine has done the access, cleared the launch bit and raised the completion flag.

The word store is a fixed lookup. The checksum word returns 0xBABA. The control word returns a value with one configuration bit set. Every other address returns zero, including the version, tracking-ID and boot-pointer words. Write accesses finish with the same handshake, but their data is thrown away.

A synchronous software reset input clears both registers, the same way power-on reset does, except that it leaves the completion flag set.

Top module: `cfgword_engine`

## Requirements
- R1: After power-on reset (rst_n low), the command register (byte offset 0x0) and the transfer register (byte offset 0x4) both read 0, so the completion flag reads clear.
- R2: A cycle with sw_rst high clears both registers and any pending access. It then sets the completion flag, so the command register reads 0x00000004 and the transfer register reads 0.
- R3: A bus cycle with bus_valid=1 and bus_write=1 to offset 0x0 or 0x4 stores bus_wdata in that register. A read returns the register value on bus_rdata at the next rising edge. Any other offset reads 0, and writes to it change nothing.
- R4: An access launches only when a command or transfer register write leaves the launch bit (command bit 0) set. A command write with bit 0 clear stores the value as written and launches nothing.
- R5: Command layout: bit 0 is the launch bit, bit 1 is the direction (1 = write, 0 = read), bit 2 is the completion flag, and bits [15:4] are the 12-bit word address. The remaining bits keep whatever software wrote.
- R6: A read access replaces transfer bits [31:16] with the 16-bit word found at the address. Transfer bits [15:0] keep their value.
- R7: An access completes at the clock edge after the triggering write: the launch bit clears and the completion flag sets. The flag then stays set until software overwrites the command register.
- R8: Word 0x03F reads 0xBABA, and word 0x00F reads 0x0002 (configuration bit 1 set). All other words read 0, including 0x017, 0x018, 0x02D and 0x02E.
- R9: A write access takes its value from transfer bits [15:0] and discards it. The transfer register is left unchanged, and later reads of the store return the same fixed values.
- R10: Writing the transfer register while the launch bit is still set launches another access. If that write lands in the completion cycle, the written value replaces the transfer register, and the new access then merges its read result into it one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sw_rst | input | 1 | Synchronous software reset; leaves the completion flag set |
| bus_valid | input | 1 | Bus request valid this cycle |
| bus_write | input | 1 | 1 = register write, 0 = register read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data, valid after the edge that accepts the read |

## Verification
The assertions assume that only one register is addressed per bus cycle and that sw_rst pulses are synchronous. The completion checks also assume software does not rewrite the command register in the completion cycle; they are gated off when it does. The random stimulus issues each bus write as a single cycle followed by an idle cycle, so every access completes before the next command arrives. The one deliberate exception is a directed transfer-register write placed in the completion cycle, which exercises the relaunch case.

// File: rtl/cfgword_pkg.sv
package cfgword_pkg;
    localparam int REG_W     = 32;
    localparam int WORD_W    = 16;
    localparam int WADDR_W   = 12;
    localparam int BUS_AW    = 4;
    localparam int LAUNCH_B  = 0;
    localparam int DIR_B     = 1;
    localparam int DONE_B    = 2;
    localparam int WADDR_LSB = 4;
    localparam int RDF_LSB   = 16;
    localparam int WRF_LSB   = 0;
    localparam logic [BUS_AW-1:0] OFS_CMD  = 4'h0;
    localparam logic [BUS_AW-1:0] OFS_XFER = 4'h4;

    typedef struct packed {
        logic [REG_W-1:0] cmd;
        logic [REG_W-1:0] xfer;
        logic             pend;
        logic [REG_W-1:0] rdata;
    } eng_state_t;
endpackage

// File: rtl/cfgword_busdec.sv
module cfgword_busdec
    import cfgword_pkg::*;
(
    input  logic              valid,
    input  logic              write,
    input  logic [BUS_AW-1:0] addr,
    output logic              wr_cmd,
    output logic              wr_xfer,
    output logic              rd_cmd,
    output logic              rd_xfer,
    output logic              rd_any
);
    logic hit_cmd, hit_xfer;

    always_comb begin
        hit_cmd  = (addr == OFS_CMD);
        hit_xfer = (addr == OFS_XFER);
        wr_cmd   = valid & write & hit_cmd;
        wr_xfer  = valid & write & hit_xfer;
        rd_cmd   = valid & ~write & hit_cmd;
        rd_xfer  = valid & ~write & hit_xfer;
        rd_any   = valid & ~write;
    end
endmodule

// File: rtl/cfgword_lookup.sv
module cfgword_lookup
    import cfgword_pkg::*;
#(
    parameter logic [WADDR_W-1:0] CSUM_ADDR = 12'h03F,
    parameter logic [WORD_W-1:0]  CSUM_VAL  = 16'hBABA,
    parameter logic [WADDR_W-1:0] CFGW_ADDR = 12'h00F,
    parameter int                 CFGW_BIT  = 1
) (
    input  logic [WADDR_W-1:0] waddr,
    output logic [WORD_W-1:0]  word
);
    localparam logic [WORD_W-1:0] CFGW_VAL = WORD_W'(1) << CFGW_BIT;

    always_comb begin
        if (waddr == CSUM_ADDR) begin
            word = CSUM_VAL;
        end else if (waddr == CFGW_ADDR) begin
            word = CFGW_VAL;
        end else begin
            word = '0;
        end
    end
endmodule

// File: rtl/cfgword_engine.sv
module cfgword_engine
    import cfgword_pkg::*;
#(
    parameter logic [WADDR_W-1:0] CSUM_ADDR = 12'h03F,
    parameter logic [WORD_W-1:0]  CSUM_VAL  = 16'hBABA,
    parameter logic [WADDR_W-1:0] CFGW_ADDR = 12'h00F,
    parameter int                 CFGW_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata
);
    eng_state_t st_d, st_q;
    logic wr_cmd, wr_xfer, rd_cmd, rd_xfer, rd_any;
    logic [WADDR_W-1:0] op_waddr;
    logic [WORD_W-1:0]  op_word;
    logic               launch_view;

    cfgword_busdec u_dec (
        .valid   (bus_valid),
        .write   (bus_write),
        .addr    (bus_addr),
        .wr_cmd  (wr_cmd),
        .wr_xfer (wr_xfer),
        .rd_cmd  (rd_cmd),
        .rd_xfer (rd_xfer),
        .rd_any  (rd_any)
    );

    assign op_waddr = st_q.cmd[WADDR_LSB +: WADDR_W];

    cfgword_lookup #(
        .CSUM_ADDR (CSUM_ADDR),
        .CSUM_VAL  (CSUM_VAL),
        .CFGW_ADDR (CFGW_ADDR),
        .CFGW_BIT  (CFGW_BIT)
    ) u_lut (
        .waddr (op_waddr),
        .word  (op_word)
    );

    always_comb begin
        st_d = st_q;
        // finish a pending access; bus writes this cycle take precedence
        if (st_q.pend) begin
            if (!wr_cmd) begin
                st_d.cmd[LAUNCH_B] = 1'b0;
                st_d.cmd[DONE_B]   = 1'b1;
            end
            if (!st_q.cmd[DIR_B] && !wr_xfer) begin
                st_d.xfer[RDF_LSB +: WORD_W] = op_word;
            end
        end
        if (wr_cmd)  st_d.cmd  = bus_wdata;
        if (wr_xfer) st_d.xfer = bus_wdata;
        launch_view = wr_cmd ? bus_wdata[LAUNCH_B] : st_q.cmd[LAUNCH_B];
        st_d.pend   = (wr_cmd | wr_xfer) & launch_view;
        if (rd_any) begin
            st_d.rdata = rd_cmd ? st_q.cmd : (rd_xfer ? st_q.xfer : '0);
        end
        if (sw_rst) begin
            st_d = '0;
            st_d.cmd[DONE_B] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (st_q.pend && !wr_cmd) |=> (st_q.cmd[DONE_B] && !st_q.cmd[LAUNCH_B]));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (st_q.cmd[DONE_B] && !wr_cmd) |=> st_q.cmd[DONE_B]);

    p_wrfield_keep_r6: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (st_q.pend && !st_q.cmd[DIR_B] && !wr_xfer)
        |=> (st_q.xfer[WORD_W-1:0] == $past(st_q.xfer[WORD_W-1:0])));

    p_write_discard_r9: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (st_q.pend && st_q.cmd[DIR_B] && !wr_xfer) |=> $stable(st_q.xfer));

    p_no_launch_r4: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (wr_cmd && !bus_wdata[LAUNCH_B]) |=> !st_q.pend);

    p_checksum_r8: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (st_q.pend && !st_q.cmd[DIR_B] && !wr_xfer && op_waddr == CSUM_ADDR)
        |=> (st_q.xfer[RDF_LSB +: WORD_W] == CSUM_VAL));

    p_swrst_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (st_q.cmd == (REG_W'(1) << DONE_B) && st_q.xfer == '0 && !st_q.pend));
endmodule

// File: tb/sim_cfgword_engine.sv
module sim_cfgword_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    logic [31:0] cmd_m, xfer_m;

    cfgword_engine u0 (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_word(input logic [11:0] a);
        if (a == 12'h03F) return 16'hBABA;
        if (a == 12'h00F) return 16'h0002;
        return 16'h0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_op();
        if (!cmd_m[1]) xfer_m[31:16] = exp_word(cmd_m[15:4]);
        cmd_m = (cmd_m & ~32'h1) | 32'h4;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        if (a == 4'h0) begin
            cmd_m = v;
            if (v[0]) model_op();
        end else if (a == 4'h4) begin
            xfer_m = v;
            if (cmd_m[0]) model_op();
        end
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v = bus_rdata;
    endtask

    task automatic chk_regs(input string req);
        logic [31:0] v;
        bus_rd(4'h0, v); chk({req, " cmd"}, v, cmd_m);
        bus_rd(4'h4, v); chk({req, " xfer"}, v, xfer_m);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [11:0] picks [6];
        void'($urandom(32'h5EED_0042));
        picks[0] = 12'h03F; picks[1] = 12'h00F; picks[2] = 12'h018;
        picks[3] = 12'h02D; picks[4] = 12'h017; picks[5] = 12'h02E;
        cmd_m = '0; xfer_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_regs("R1 power-on");

        // R3 plain storage without launch, unmapped offset
        bus_wr(4'h4, 32'hA5A5_1234);
        bus_wr(4'h0, 32'hF0F0_0AA8);
        chk_regs("R3 store");
        bus_wr(4'h8, 32'hFFFF_FFFF);
        bus_rd(4'h8, v); chk("R3 unmapped read", v, 32'h0);
        chk_regs("R3 unmapped write ignored");

        // R4: command write without launch leaves transfer and flags as written
        bus_wr(4'h0, 32'h0000_03F0);
        chk_regs("R4 no launch");

        // R8 table, R6 field merge, R5 address field
        for (int i = 0; i < 6; i++) begin
            bus_wr(4'h4, 32'h1111_C3C3);
            bus_wr(4'h0, {16'h8000, picks[i], 4'h1});
            chk_regs("R8 R6 table read");
        end

        // R7 done held over idle cycles
        repeat (5) @(negedge clk);
        bus_rd(4'h0, v); chk("R7 done held", v[2:0], 3'b100);

        // R9 write access discards data
        bus_wr(4'h4, 32'h2222_BEEF);
        bus_wr(4'h0, {16'h0, 12'h03F, 4'h3});
        chk_regs("R9 write discard");
        bus_wr(4'h0, {16'h0, 12'h03F, 4'h1});
        chk_regs("R9 store unchanged");

        // R10 transfer write in the completion cycle relaunches
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'h0; bus_wdata = {16'h0, 12'h00F, 4'h1};
        @(negedge clk);
        bus_addr = 4'h4; bus_wdata = 32'h7777_5555;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        cmd_m = 32'h0000_00F4; xfer_m = 32'h0002_5555;
        chk_regs("R10 relaunch");

        // random mix
        for (int n = 0; n < 150; n++) begin
            logic [11:0] wa;
            logic [3:0]  fl;
            wa = ($urandom % 3 == 0) ? 12'($urandom) : picks[$urandom % 6];
            fl = 4'($urandom) & 4'b1011;
            bus_wr(4'h4, $urandom);
            bus_wr(4'h0, {16'($urandom), wa, fl});
            chk_regs("R5 R6 R8 random");
        end

        // R2 software reset
        bus_wr(4'h4, 32'hDEAD_BEEF);
        @(negedge clk); sw_rst = 1'b1;
        @(negedge clk); sw_rst = 1'b0;
        cmd_m = 32'h4; xfer_m = '0;
        chk_regs("R2 soft reset");

        // R1 power-on reset after soft reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        cmd_m = '0;
        chk_regs("R1 reset again");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule